// File: doc/BRIEF.md
# Landing Gear Sequencing Controller

This block is a synchronous five-state machine that sequences a retractable landing gear and the bay door covering it. A one-bit command asks for the gear to be down (1) or up (0). Four position sensors report the door (open, closed) and the gear (in, out). The controller drives one of four actuators at a time: door open, door close, gear extend or gear retract. It also reports its current state as a 3-bit code and raises a fault flag when the sensors contradict each other.

The transitions are decided from named sensor combinations, including those seen while the door or the gear is between its end stops. As a result the machine resumes correctly when the command reverses part-way through a sequence. Examples are a reopen of a half-closed door, or a reversal of the gear while it is moving. The sensor decode and the actuator gating sit in a datapath module. The state register and the transition choice sit in a control module. The control module passes its actuator requests to the datapath as a small strobe bundle.

Top module: `landing_gear_seq`

## Requirements
- R1: A synchronous active-high reset puts the machine in Idle, code 0, and deasserts every actuator drive in the cycle after the reset edge.
- R2: The state code output is Idle=0, Opening=1, Extending=2, Retracting=3 and Closing=4. When no fault is present, the drives follow the state. Opening drives only door-open. Extending drives only gear-extend. Retracting drives only gear-retract. Closing drives only door-close. Idle drives nothing. At most one drive is ever high.
- R3: Sensor combinations used below:
  - DS (door shut): door-closed is 1 and door-open is 0.
  - DM (door mid): both door sensors are 0.
  - GO (gear out only): gear-out is 1 and gear-in is 0.
  - GI (gear in only): gear-in is 1 and gear-out is 0.

  From Idle the machine enters Opening when either of two cases holds: the command is 0 with DM&GO or DS&GO, or the command is 1 with DM&GI or DS&GI.
- R4: From Idle, when the R3 case does not hold, the machine enters Closing when the gear already matches the command but the door is not shut. That is the case when either of two conditions holds: the command is 1 with GO and the door either mid or open-only, or the command is 0 with GI and the door either mid or open-only. Open-only means door-open is 1 and door-closed is 0. Otherwise the machine stays in Idle.
- R5: Opening ends when door-open is 1, or when DS holds with both gear sensors 0. The next state is then Extending if the command is 1 and Retracting if it is 0. Otherwise the machine stays in Opening.
- R6: In Extending, a command of 0 moves the machine to Retracting. Otherwise the machine moves to Closing when gear-out is 1. Otherwise it moves back to Opening when DM&GI holds. Otherwise it stays in Extending.
- R7: In Retracting, a command of 1 moves the machine to Extending. Otherwise the machine moves to Closing when gear-in is 1. Otherwise it stays in Retracting.
- R8: In Closing, door-closed set to 1 returns the machine to Idle. Otherwise it stays in Closing, whatever the command.
- R9: A fault exists when door-open and door-closed are both 1, or when gear-in and gear-out are both 1. While a fault exists, the fault flag is 1 and all four drives are 0 in that same cycle, and the next state is Idle from any state. Without a fault, the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gearCmd | input | 1 | 1 = gear down requested, 0 = gear up requested |
| doorOpenSns | input | 1 | Door fully open sensor |
| doorClosedSns | input | 1 | Door fully closed sensor |
| gearInSns | input | 1 | Gear stowed sensor |
| gearOutSns | input | 1 | Gear deployed sensor |
| driveOpen | output | 1 | Door open actuator |
| driveClose | output | 1 | Door close actuator |
| driveExtend | output | 1 | Gear extend actuator |
| driveRetract | output | 1 | Gear retract actuator |
| sensorFault | output | 1 | Contradictory sensor pair present |
| seqState | output | 3 | Current state code |

## Verification
The block has no size parameter, so the bench builds it as written. The reachable space is small enough to cover completely: five states, each driven with all 32 combinations of command and sensors. Every guard is therefore reached, in every state, under every combination of the other inputs, including all fault patterns and all mid-travel cases. A reset during an active sequence is also exercised.

// File: rtl/landing_gear_seq_pkg.sv
package landing_gear_seq_pkg;

  localparam int NUM_ACT   = 4;
  localparam int STATE_W   = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE       = 3'd0,
    ST_OPENING    = 3'd1,
    ST_EXTENDING  = 3'd2,
    ST_RETRACTING = 3'd3,
    ST_CLOSING    = 3'd4
  } seqState_e;

  // raw sensor bundle
  typedef struct packed {
    logic doorOpen;
    logic doorClosed;
    logic gearIn;
    logic gearOut;
  } sensors_t;

  // decoded sensor combinations handed to the control
  typedef struct packed {
    logic doorOpen;
    logic doorClosed;
    logic gearIn;
    logic gearOut;
    logic shutNoGear;    // door shut, gear between stops
    logic shutGearOut;   // door shut, gear out only
    logic shutGearIn;    // door shut, gear in only
    logic openGearOut;   // door open only, gear out only
    logic openGearIn;    // door open only, gear in only
    logic midGearOut;    // door in transit, gear out only
    logic midGearIn;     // door in transit, gear in only
    logic fault;         // contradictory pair
  } senseCond_t;

  // actuator request strobes from control to datapath
  typedef struct packed {
    logic open;
    logic close;
    logic extend;
    logic retract;
  } driveStrobe_t;

endpackage

// File: rtl/landing_gear_seq_datapath.sv
module landing_gear_seq_datapath
  import landing_gear_seq_pkg::*;
(
  input  sensors_t                 sns,
  input  driveStrobe_t             req,
  output senseCond_t               cond,
  output logic [NUM_ACT-1:0]       drive,
  output logic                     fault
);

  logic doorShut, doorOpenOnly, doorMid;
  logic gearOutOnly, gearInOnly, gearNone;
  logic [NUM_ACT-1:0] reqVec;

  always_comb begin
    doorShut     = sns.doorClosed & ~sns.doorOpen;
    doorOpenOnly = sns.doorOpen & ~sns.doorClosed;
    doorMid      = ~sns.doorOpen & ~sns.doorClosed;
    gearOutOnly  = sns.gearOut & ~sns.gearIn;
    gearInOnly   = sns.gearIn & ~sns.gearOut;
    gearNone     = ~sns.gearIn & ~sns.gearOut;
  end

  always_comb begin
    cond.doorOpen    = sns.doorOpen;
    cond.doorClosed  = sns.doorClosed;
    cond.gearIn      = sns.gearIn;
    cond.gearOut     = sns.gearOut;
    cond.shutNoGear  = doorShut & gearNone;
    cond.shutGearOut = doorShut & gearOutOnly;
    cond.shutGearIn  = doorShut & gearInOnly;
    cond.openGearOut = doorOpenOnly & gearOutOnly;
    cond.openGearIn  = doorOpenOnly & gearInOnly;
    cond.midGearOut  = doorMid & gearOutOnly;
    cond.midGearIn   = doorMid & gearInOnly;
    cond.fault       = (sns.doorOpen & sns.doorClosed) | (sns.gearIn & sns.gearOut);
  end

  assign fault  = cond.fault;
  assign reqVec = req;

  // every actuator is gated off while the sensors contradict
  for (genvar g = 0; g < NUM_ACT; g++) begin : g_gate
    assign drive[g] = reqVec[g] & ~cond.fault;
  end

endmodule

// File: rtl/landing_gear_seq_ctrl.sv
module landing_gear_seq_ctrl
  import landing_gear_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         cmdDown,
  input  senseCond_t   cond,
  output seqState_e    state,
  output driveStrobe_t req
);

  seqState_e stateNext;
  logic wantOpen, wantClose;

  always_comb begin
    wantOpen  = (~cmdDown & (cond.midGearOut | cond.shutGearOut)) |
                ( cmdDown & (cond.midGearIn  | cond.shutGearIn));
    wantClose = ( cmdDown & (cond.midGearOut | cond.openGearOut)) |
                (~cmdDown & (cond.midGearIn  | cond.openGearIn));
  end

  always_comb begin
    stateNext = state;
    if (cond.fault) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (wantOpen)       stateNext = ST_OPENING;
          else if (wantClose) stateNext = ST_CLOSING;
        end
        ST_OPENING: begin
          if (cond.doorOpen | cond.shutNoGear)
            stateNext = cmdDown ? ST_EXTENDING : ST_RETRACTING;
        end
        ST_EXTENDING: begin
          if (!cmdDown)            stateNext = ST_RETRACTING;
          else if (cond.gearOut)   stateNext = ST_CLOSING;
          else if (cond.midGearIn) stateNext = ST_OPENING;
        end
        ST_RETRACTING: begin
          if (cmdDown)            stateNext = ST_EXTENDING;
          else if (cond.gearIn)   stateNext = ST_CLOSING;
        end
        ST_CLOSING: begin
          if (cond.doorClosed) stateNext = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    req = '0;
    case (state)
      ST_OPENING:    req.open    = 1'b1;
      ST_EXTENDING:  req.extend  = 1'b1;
      ST_RETRACTING: req.retract = 1'b1;
      ST_CLOSING:    req.close   = 1'b1;
      default:       req = '0;
    endcase
  end

endmodule

// File: rtl/landing_gear_seq.sv
module landing_gear_seq
  import landing_gear_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       gearCmd,
  input  logic       doorOpenSns,
  input  logic       doorClosedSns,
  input  logic       gearInSns,
  input  logic       gearOutSns,
  output logic       driveOpen,
  output logic       driveClose,
  output logic       driveExtend,
  output logic       driveRetract,
  output logic       sensorFault,
  output logic [2:0] seqState
);

  sensors_t           sns;
  senseCond_t         cond;
  driveStrobe_t       req;
  seqState_e          state;
  logic [NUM_ACT-1:0] drive;

  assign sns = '{doorOpen: doorOpenSns, doorClosed: doorClosedSns,
                 gearIn: gearInSns, gearOut: gearOutSns};

  landing_gear_seq_datapath u_dp (
    .sns   (sns),
    .req   (req),
    .cond  (cond),
    .drive (drive),
    .fault (sensorFault)
  );

  landing_gear_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cmdDown (gearCmd),
    .cond    (cond),
    .state   (state),
    .req     (req)
  );

  // drive vector order follows the strobe struct: open, close, extend, retract
  assign {driveOpen, driveClose, driveExtend, driveRetract} = drive;
  assign seqState = state;

endmodule

// File: rtl/landing_gear_seq_chk.sv
module landing_gear_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       gearCmd,
  input logic       doorClosedSns,
  input logic       driveOpen,
  input logic       driveClose,
  input logic       driveExtend,
  input logic       driveRetract,
  input logic       sensorFault,
  input logic [2:0] seqState
);

  logic rstQ;
  always_ff @(posedge clk) rstQ <= rst;

  // R1: state and drives cleared after a reset edge
  always @(negedge clk) begin
    if (rstQ) begin
      a_r1_reset_idle: assert (seqState == 3'd0 &&
        {driveOpen, driveClose, driveExtend, driveRetract} == 4'b0000);
    end
  end

  a_r2_one_drive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({driveOpen, driveClose, driveExtend, driveRetract}));

  a_r9_fault_quiet: assert property (@(posedge clk) disable iff (rst)
    sensorFault |-> ({driveOpen, driveClose, driveExtend, driveRetract} == 4'b0000));

  a_r9_fault_idle: assert property (@(posedge clk) disable iff (rst)
    sensorFault |=> (seqState == 3'd0));

  a_r6_extend_reverse: assert property (@(posedge clk) disable iff (rst)
    (seqState == 3'd2 && !gearCmd && !sensorFault) |=> (seqState == 3'd3));

  a_r7_retract_reverse: assert property (@(posedge clk) disable iff (rst)
    (seqState == 3'd3 && gearCmd && !sensorFault) |=> (seqState == 3'd2));

  a_r8_closing_done: assert property (@(posedge clk) disable iff (rst)
    (seqState == 3'd4 && doorClosedSns && !sensorFault) |=> (seqState == 3'd0));

endmodule

bind landing_gear_seq landing_gear_seq_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .gearCmd       (gearCmd),
  .doorClosedSns (doorClosedSns),
  .driveOpen     (driveOpen),
  .driveClose    (driveClose),
  .driveExtend   (driveExtend),
  .driveRetract  (driveRetract),
  .sensorFault   (sensorFault),
  .seqState      (seqState)
);

// File: tb/landing_gear_seq_test.sv
module landing_gear_seq_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gearCmd = 1'b0, doorOpenSns = 1'b0, doorClosedSns = 1'b0;
  logic gearInSns = 1'b0, gearOutSns = 1'b0;
  logic driveOpen, driveClose, driveExtend, driveRetract, sensorFault;
  logic [2:0] seqState;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  landing_gear_seq uut (
    .clk(clk), .rst(rst), .gearCmd(gearCmd),
    .doorOpenSns(doorOpenSns), .doorClosedSns(doorClosedSns),
    .gearInSns(gearInSns), .gearOutSns(gearOutSns),
    .driveOpen(driveOpen), .driveClose(driveClose),
    .driveExtend(driveExtend), .driveRetract(driveRetract),
    .sensorFault(sensorFault), .seqState(seqState)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected next state from the requirements; pat = {cmd, open, closed, in, out}
  function automatic int modelNext(input int st, input logic [4:0] pat);
    logic c, o, s, i, u;
    logic shut, opn, mid, go, gi, gn;
    {c, o, s, i, u} = pat;
    if ((o & s) | (i & u)) return 0;
    shut = s & ~o; opn = o & ~s; mid = ~o & ~s;
    go = u & ~i; gi = i & ~u; gn = ~i & ~u;
    case (st)
      0: begin
        if ((!c & ((mid & go) | (shut & go))) | (c & ((mid & gi) | (shut & gi)))) return 1;
        if ((c & ((mid & go) | (opn & go))) | (!c & ((mid & gi) | (opn & gi)))) return 4;
        return 0;
      end
      1: return (o | (shut & gn)) ? (c ? 2 : 3) : 1;
      2: begin
        if (!c) return 3;
        if (u) return 4;
        if (mid & gi) return 1;
        return 2;
      end
      3: begin
        if (c) return 2;
        if (i) return 4;
        return 3;
      end
      default: return s ? 0 : 4;
    endcase
  endfunction

  // expected drives {open, close, extend, retract}
  function automatic int modelDrive(input int st, input bit flt);
    if (flt) return 0;
    case (st)
      1: return 8;
      2: return 2;
      3: return 1;
      4: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic string tagFor(input int st, input int nxt, input bit flt);
    if (flt) return "R9";
    case (st)
      0: return (nxt == 4) ? "R4" : "R3";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      default: return "R8";
    endcase
  endfunction

  // inputs change just after a falling edge; results sampled at the next falling edge
  task automatic setIn(input logic [4:0] pat);
    {gearCmd, doorOpenSns, doorClosedSns, gearInSns, gearOutSns} = pat;
  endtask

  task automatic stepIn(input logic [4:0] pat);
    setIn(pat);
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    setIn(5'b0);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic goTo(input int st);
    doReset();
    case (st)
      1: stepIn(5'b0_01_01);
      2: begin stepIn(5'b0_01_01); stepIn(5'b1_10_00); end
      3: begin stepIn(5'b0_01_01); stepIn(5'b0_10_00); end
      4: stepIn(5'b1_10_01);
      default: ;
    endcase
    check(seqState == 3'(st), (st == 4) ? "R4" : ((st == 1) ? "R3" : "R5"),
          int'(seqState), st);
  endtask

  initial begin
    // R1: reset state
    doReset();
    check(seqState == 3'd0, "R1", int'(seqState), 0);
    check({driveOpen, driveClose, driveExtend, driveRetract} == 4'd0, "R1",
          int'({driveOpen, driveClose, driveExtend, driveRetract}), 0);

    // R1: reset while extending
    goTo(2);
    rst = 1'b1;
    @(negedge clk);
    check(seqState == 3'd0, "R1", int'(seqState), 0);
    check({driveOpen, driveClose, driveExtend, driveRetract} == 4'd0, "R1",
          int'({driveOpen, driveClose, driveExtend, driveRetract}), 0);
    rst = 1'b0;

    // full sweep: each state against all 32 input patterns
    for (int st = 0; st < 5; st++) begin
      for (int p = 0; p < 32; p++) begin
        logic [4:0] pat;
        bit flt;
        int expN, expD, actD;
        pat = 5'(p);
        flt = (pat[3] & pat[2]) | (pat[1] & pat[0]);
        goTo(st);
        setIn(pat);
        #1;
        expD = modelDrive(st, flt);
        actD = int'({driveOpen, driveClose, driveExtend, driveRetract});
        check(actD == expD, flt ? "R9" : "R2", actD, expD);
        check(sensorFault == flt, "R9", int'(sensorFault), int'(flt));
        @(negedge clk);
        expN = modelNext(st, pat);
        check(int'(seqState) == expN, tagFor(st, expN, flt), int'(seqState), expN);
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule